// File: doc/BRIEF.md
# Dual-Pointer Video Memory Access Port

This block gives a processor byte-wide access to a private video memory through a small register window. It has two data ports. Each port has its own 17-bit address pointer, its own step and direction setting, and its own data register. A read of a data port returns the byte already waiting in that port's data register. The read then moves the pointer by the port's step. A write to a data port stores the byte at the pointer and then moves the pointer. Each time a pointer changes or is rewritten, a fetch is queued that reloads the port's data register from the new location.

The data register is refreshed only by its own port's pointer activity. Memory can change underneath it, for example through the other port, and the data register will not notice. To get the current value, software rewrites any address byte of the port, even with the same value. The memory is a single-ported byte RAM. A fixed-priority arbiter shares it between stores and the two ports' fetches. Bus strobes must be spaced at least four clock cycles apart. Under that rule every access, including its fetch, finishes before the next strobe, so the processor never waits.

Top module: `vram_port_top`

## Requirements
- R1: After reset both pointers, steps, direction bits and data registers are zero, the port-select control is zero and `bus_rdata` reads zero.
- R2: Window offsets 0, 1 and 2 hold pointer bits 7:0, bits 15:8, and the step/direction/bank byte. They act on the port chosen by bit 0 of offset 5, and they read back what was written. The two ports' pointers are independent.
- R3: A read strobe at offset 3 (port 0) or offset 4 (port 1) puts that port's data register on `bus_rdata` in the next cycle. That port's pointer then moves by its step. `bus_rdata` changes only after read strobes.
- R4: A write strobe at offset 3 or 4 stores `bus_wdata` at the port's current pointer, then moves the pointer by the port's step.
- R5: In the byte at offset 2, bits 7:4 are a step code: code 0 means no movement and code k means a step of 2^(k-1). Bit 3 set means the pointer moves down instead of up. Bit 0 is pointer bit 16. Pointer arithmetic wraps modulo 2^17.
- R6: Any write to offset 0, 1 or 2 reloads the selected port's data register from its new pointer, even if the value written equals the old one.
- R7: A port's data register changes only when that port's own fetch completes. A store through the other port to the same location leaves it stale.
- R8: Stores are served before fetches, and a port 0 fetch is served before a port 1 fetch. A store and a fetch queued by the same strobe both complete before a strobe four cycles later, so a fetch that follows a store sees the stored byte.
- R9: The memory holds 2^RAM_AW bytes. Pointer bits at or above RAM_AW are ignored when the memory is addressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | One-cycle bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | 3 | Register window offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read strobe |

## Verification
The assertions check the following on every cycle:
- at most one memory grant at a time, and the arbiter serves any pending fetch whenever it has no store;
- nothing is still in flight when a new strobe arrives;
- `bus_rdata` holds between read strobes;
- each data-port access moves the pointer by the decoded step in the programmed direction;
- a data register changes only in the cycle after its own fetch.

Only the bench scenarios can show that the returned bytes are correct: the stale value after a store through the other port, the refresh after rewriting an unchanged address byte, the fetch that follows a store seeing the new byte, downward wrap past zero, and aliasing of high pointer bits onto the small memory.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  typedef enum logic [2:0] {
    REG_ALO   = 3'd0,
    REG_AMID  = 3'd1,
    REG_AHI   = 3'd2,
    REG_DATA0 = 3'd3,
    REG_DATA1 = 3'd4,
    REG_CTRL  = 3'd5
  } reg_off_e;

  localparam int BYTE_W = 8;
  localparam int STEP_CODE_W = 4;

endpackage

// File: rtl/vram_ram.sv
module vram_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/vram_addr_ptr.sv
module vram_addr_ptr #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 17,
  parameter int INC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_mid,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              advance,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [INC_W-1:0]  inc_o,
  output logic              dec_o,
  output logic [1:0]        rsv_o,
  output logic [DATA_W-1:0] dreg_o,
  output logic              fetch_req_o
);
  logic [PTR_W-1:0] step;

  always_comb begin
    if (inc_o == '0) step = '0;
    else step = {{(PTR_W-1){1'b0}}, 1'b1} << (inc_o - INC_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o  <= '0;
      inc_o  <= '0;
      dec_o  <= 1'b0;
      rsv_o  <= '0;
      dreg_o <= '0;
    end else begin
      if (wr_lo)  ptr_o[DATA_W-1:0] <= wdata;
      if (wr_mid) ptr_o[2*DATA_W-1:DATA_W] <= wdata;
      if (wr_hi) begin
        ptr_o[PTR_W-1] <= wdata[0];
        rsv_o          <= wdata[2:1];
        dec_o          <= wdata[3];
        inc_o          <= wdata[DATA_W-1:DATA_W-INC_W];
      end
      if (advance) ptr_o <= dec_o ? ptr_o - step : ptr_o + step;
      if (fill_en) dreg_o <= fill_data;
    end
  end

  assign fetch_req_o = wr_lo | wr_mid | wr_hi | advance;
endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter #(
  parameter int NP     = 2,
  parameter int RAM_AW = 11,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_req,
  input  logic [RAM_AW-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [NP-1:0]              fetch_req,
  input  logic [NP-1:0][RAM_AW-1:0]  fetch_addr,
  output logic                       ram_en,
  output logic                       ram_we,
  output logic [RAM_AW-1:0]          ram_addr,
  output logic [DATA_W-1:0]          ram_wdata,
  output logic [NP-1:0]              fill_vld,
  output logic                       gnt_wr,
  output logic [NP-1:0]              gnt_f,
  output logic                       wr_pend,
  output logic [NP-1:0]              f_pend
);
  logic [RAM_AW-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  always_comb begin
    logic taken;
    taken    = 1'b0;
    gnt_wr   = wr_pend;
    gnt_f    = '0;
    ram_addr = wr_addr_q;
    if (!wr_pend) begin
      for (int i = 0; i < NP; i++) begin
        if (f_pend[i] && !taken) begin
          gnt_f[i] = 1'b1;
          ram_addr = fetch_addr[i];
          taken    = 1'b1;
        end
      end
    end
  end

  assign ram_en    = gnt_wr | (|gnt_f);
  assign ram_we    = gnt_wr;
  assign ram_wdata = wr_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      f_pend    <= '0;
      fill_vld  <= '0;
    end else begin
      if (wr_req) begin
        wr_pend   <= 1'b1;
        wr_addr_q <= wr_addr;
        wr_data_q <= wr_data;
      end else if (gnt_wr) begin
        wr_pend <= 1'b0;
      end
      f_pend   <= (f_pend & ~gnt_f) | fetch_req;
      fill_vld <= gnt_f;
    end
  end
endmodule

// File: rtl/vram_port_top.sv
module vram_port_top
  import vram_port_pkg::*;
#(
  parameter int RAM_AW = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int DATA_W = BYTE_W;
  localparam int PTR_W  = 2 * DATA_W + 1;
  localparam int INC_W  = STEP_CODE_W;
  localparam int NP     = 2;

  logic port_sel;
  logic wr_cyc;

  logic [NP-1:0]              wr_lo, wr_mid, wr_hi, adv, fetch_req, fill_vld;
  logic [NP-1:0][PTR_W-1:0]   ptr_w;
  logic [NP-1:0][INC_W-1:0]   inc_w;
  logic [NP-1:0]              dec_w;
  logic [NP-1:0][1:0]         rsv_w;
  logic [NP-1:0][DATA_W-1:0]  dreg_w;
  logic [NP-1:0][RAM_AW-1:0]  fetch_addr;

  logic              ram_en, ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic              wr_req;
  logic [RAM_AW-1:0] wr_addr;
  logic              gnt_wr, wr_pend_w;
  logic [NP-1:0]     gnt_f, f_pend_w;

  assign wr_cyc = bus_sel & bus_we;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam logic [2:0] DOFF = 3'(int'(REG_DATA0) + p);

    assign wr_lo[p]      = wr_cyc && (bus_addr == REG_ALO)  && (port_sel == 1'(p));
    assign wr_mid[p]     = wr_cyc && (bus_addr == REG_AMID) && (port_sel == 1'(p));
    assign wr_hi[p]      = wr_cyc && (bus_addr == REG_AHI)  && (port_sel == 1'(p));
    assign adv[p]        = bus_sel && (bus_addr == DOFF);
    assign fetch_addr[p] = ptr_w[p][RAM_AW-1:0];

    vram_addr_ptr #(
      .DATA_W(DATA_W),
      .PTR_W (PTR_W),
      .INC_W (INC_W)
    ) u_ptr (
      .clk        (clk),
      .rst        (rst),
      .wr_lo      (wr_lo[p]),
      .wr_mid     (wr_mid[p]),
      .wr_hi      (wr_hi[p]),
      .wdata      (bus_wdata),
      .advance    (adv[p]),
      .fill_en    (fill_vld[p]),
      .fill_data  (ram_q),
      .ptr_o      (ptr_w[p]),
      .inc_o      (inc_w[p]),
      .dec_o      (dec_w[p]),
      .rsv_o      (rsv_w[p]),
      .dreg_o     (dreg_w[p]),
      .fetch_req_o(fetch_req[p])
    );
  end

  assign wr_req  = wr_cyc && ((bus_addr == REG_DATA0) || (bus_addr == REG_DATA1));
  assign wr_addr = (bus_addr == REG_DATA1) ? fetch_addr[1] : fetch_addr[0];

  vram_arbiter #(
    .NP    (NP),
    .RAM_AW(RAM_AW),
    .DATA_W(DATA_W)
  ) u_arb (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (bus_wdata),
    .fetch_req (fetch_req),
    .fetch_addr(fetch_addr),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .fill_vld  (fill_vld),
    .gnt_wr    (gnt_wr),
    .gnt_f     (gnt_f),
    .wr_pend   (wr_pend_w),
    .f_pend    (f_pend_w)
  );

  vram_ram #(
    .AW(RAM_AW),
    .DW(DATA_W)
  ) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) port_sel <= 1'b0;
    else if (wr_cyc && bus_addr == REG_CTRL) port_sel <= bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      case (bus_addr)
        REG_ALO:   bus_rdata <= ptr_w[port_sel][DATA_W-1:0];
        REG_AMID:  bus_rdata <= ptr_w[port_sel][2*DATA_W-1:DATA_W];
        REG_AHI:   bus_rdata <= {inc_w[port_sel], dec_w[port_sel], rsv_w[port_sel],
                                 ptr_w[port_sel][PTR_W-1]};
        REG_DATA0: bus_rdata <= dreg_w[0];
        REG_DATA1: bus_rdata <= dreg_w[1];
        REG_CTRL:  bus_rdata <= {{(DATA_W-1){1'b0}}, port_sel};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vram_port_checker.sv
module vram_port_checker #(
  parameter int NP     = 2,
  parameter int PTR_W  = 17,
  parameter int INC_W  = 4,
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_sel,
  input logic                      bus_we,
  input logic [2:0]                bus_addr,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic                      gnt_wr,
  input logic [NP-1:0]             gnt_f,
  input logic                      wr_pend,
  input logic [NP-1:0]             f_pend,
  input logic [NP-1:0]             fill_vld,
  input logic [NP-1:0][PTR_W-1:0]  ptr,
  input logic [NP-1:0][INC_W-1:0]  inc,
  input logic [NP-1:0]             dec,
  input logic [NP-1:0][DATA_W-1:0] dreg
);
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_wr, gnt_f}));

  assert_fetch_served_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_pend && (|f_pend)) |-> (|gnt_f));

  assert_idle_at_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    bus_sel |-> (!wr_pend && f_pend == '0 && fill_vld == '0));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));

  for (genvar p = 0; p < NP; p++) begin : g_chk
    logic [PTR_W-1:0] stp;
    always_comb stp = (inc[p] == '0) ? '0 : PTR_W'(2 ** (int'(inc[p]) - 1));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_addr == 3'(3 + p)) |=>
      (ptr[p] == ($past(dec[p]) ? $past(ptr[p]) - $past(stp) : $past(ptr[p]) + $past(stp))));

    assert_stale_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(dreg[p]) |-> $past(fill_vld[p]));
  end
endmodule

bind vram_port_top vram_port_checker #(
  .NP(NP), .PTR_W(PTR_W), .INC_W(INC_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .gnt_wr(gnt_wr), .gnt_f(gnt_f), .wr_pend(wr_pend_w),
  .f_pend(f_pend_w), .fill_vld(fill_vld), .ptr(ptr_w), .inc(inc_w), .dec(dec_w),
  .dreg(dreg_w)
);

// File: tb/vram_port_top_test.sv
module vram_port_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic rd_issued = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  vram_port_top #(.RAM_AW(11)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    rd_issued <= bus_sel && !bus_we;
  end

  // monitor: pops expected bytes in the cycle after each read strobe
  always @(negedge clk) begin
    if (rd_issued) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        failures++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] off, input logic [7:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = off; bus_wdata = val;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = off;
    @(negedge clk);
    bus_sel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cycles >= 20000);
    failures++;
    $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (bus_rdata !== 8'h00) begin
      failures++;
      $display("FAIL R1: rdata=%02h expected=00", bus_rdata);
    end
    rd(3'd5, 8'h00, "R1 ctrl");
    rd(3'd0, 8'h00, "R1 lo");
    rd(3'd1, 8'h00, "R1 mid");
    rd(3'd2, 8'h00, "R1 hi");
    rd(3'd3, 8'h00, "R1 data0");

    // R2 window readback and port independence
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd2, 8'h10);
    rd(3'd0, 8'h34, "R2 lo");
    rd(3'd1, 8'h12, "R2 mid");
    rd(3'd2, 8'h10, "R2 hi");
    wr(3'd5, 8'h01);
    rd(3'd5, 8'h01, "R2 ctrl");
    rd(3'd0, 8'h00, "R2 port1 lo independent");
    wr(3'd5, 8'h00);
    rd(3'd0, 8'h34, "R2 port0 lo kept");

    // R4 fill 0x100..0x104 through port 0
    wr(3'd0, 8'h00); wr(3'd1, 8'h01);
    wr(3'd3, 8'hBB);
    for (int i = 0; i < 4; i++) wr(3'd3, 8'hAA);
    rd(3'd0, 8'h05, "R4 pointer after stores");

    // R3 reads return prefetched bytes and advance
    wr(3'd0, 8'h00);
    rd(3'd3, 8'hBB, "R3 first byte");
    rd(3'd3, 8'hAA, "R3 second byte");
    rd(3'd0, 8'h02, "R3 pointer advanced");

    // R7 stale prefetch after store through port 1
    wr(3'd5, 8'h01); wr(3'd0, 8'h02); wr(3'd1, 8'h01); wr(3'd2, 8'h10);
    wr(3'd4, 8'h77);
    rd(3'd3, 8'hAA, "R7 stale data0");

    // R6 refresh by rewriting unchanged address bytes
    wr(3'd4, 8'hCC);
    wr(3'd5, 8'h00); wr(3'd0, 8'h03);
    rd(3'd3, 8'hCC, "R6 refetch via lo");
    wr(3'd4, 8'h99);
    wr(3'd2, 8'h10);
    rd(3'd3, 8'h99, "R6 refetch via hi");

    // R3 port 1 read
    wr(3'd5, 8'h01); wr(3'd0, 8'h02); wr(3'd1, 8'h01);
    rd(3'd4, 8'h77, "R3 port1 data");
    wr(3'd5, 8'h00);

    // R5 step codes and decrement
    wr(3'd0, 8'h00); wr(3'd2, 8'h30);
    rd(3'd3, 8'hBB, "R5 step4 byte");
    rd(3'd0, 8'h04, "R5 step4 pointer");
    wr(3'd2, 8'h28);
    rd(3'd3, 8'h99, "R5 down byte");
    rd(3'd3, 8'h77, "R5 down prefetch");
    rd(3'd0, 8'h00, "R5 down pointer");
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h18);
    wr(3'd3, 8'h5A);
    rd(3'd0, 8'hFF, "R5 wrap lo");
    rd(3'd1, 8'hFF, "R5 wrap mid");
    rd(3'd2, 8'h19, "R5 wrap hi");

    // R9 aliasing of upper pointer bits
    wr(3'd2, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'h08);
    rd(3'd3, 8'h5A, "R9 alias byte");
    rd(3'd0, 8'h00, "R5 step zero lo");
    rd(3'd1, 8'h08, "R5 step zero mid");

    // R8 store served before the fetch queued with it
    wr(3'd1, 8'h03);
    wr(3'd3, 8'h66);
    rd(3'd3, 8'h66, "R8 fetch sees store");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R3: pending=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule